// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Status Flags

This block is a purely combinational arithmetic logic unit of configurable width. Its datapath is a row of identical one-bit slices. Each slice offers only three paths: AND, OR and a full-adder sum. The carry out of each slice feeds the carry into the next slice up. Subtraction and NOR need no paths of their own. Two operand-inversion controls produce them instead, and the B-inversion control also acts as the carry into the lowest slice.

Beside the result, the block reports four status flags: sign, zero, signed (two's-complement) overflow and unsigned carry-out. Overflow and carry-out have meaning only when the sum path is selected, and they read 0 otherwise. A user drives the operands and the four control bits, and reads the result and the flags in the same cycle.

Top module: `alu_sliced_core`

## Requirements
- R1: With {inv_a, neg_b, op_sel} = 0,0,00 the result is opnd_a AND opnd_b.
- R2: With {inv_a, neg_b, op_sel} = 0,0,01 the result is opnd_a OR opnd_b.
- R3: With {inv_a, neg_b, op_sel} = 0,0,10 the result is (opnd_a + opnd_b) modulo 2^WIDTH, and flag_carry is bit WIDTH of the full sum.
- R4: With {inv_a, neg_b, op_sel} = 0,1,10 the result is (opnd_a - opnd_b) modulo 2^WIDTH, computed as A + ~B + 1. flag_carry is 1 exactly when opnd_a >= opnd_b, taking both as unsigned.
- R5: With {inv_a, neg_b, op_sel} = 1,1,00 the result is NOT (opnd_a OR opnd_b).
- R6: For an arithmetic code, flag_ovf is 1 exactly when the two adder inputs (after inversion) share a sign and the result's sign differs from it. For example, 0111 + 0001 sets overflow and clears carry. Inputs of opposite sign never set overflow.
- R7: A carry out of the top slice alone does not set flag_ovf. For example, 1001 + 1111 gives 1000 with flag_carry=1 and flag_ovf=0.
- R8: flag_sign equals result bit WIDTH-1. flag_zero is 1 exactly when every result bit is 0.
- R9: When op_sel[1] is 0 (a logical path), flag_ovf and flag_carry are both 0.
- R10: Every other control code gives a defined result. op_sel 00 selects AND and 01 selects OR, each taken on the inverted operands. Codes 10 and 11 both select the sum of the inverted operands plus neg_b, and neg_b is the carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| inv_a | input | 1 | Complement every bit of A before the slices |
| neg_b | input | 1 | Complement every bit of B and carry 1 into the lowest slice |
| op_sel | input | 2 | Slice path: 00 AND, 01 OR, 1x sum |
| result | output | WIDTH | Selected slice outputs |
| flag_sign | output | 1 | Most significant result bit |
| flag_zero | output | 1 | All result bits are 0 |
| flag_ovf | output | 1 | Signed overflow on an arithmetic code |
| flag_carry | output | 1 | Carry out of the top slice on an arithmetic code |

## Verification
The bench builds the block with its default WIDTH of 4. At that width, all 256 operand pairs can be swept under every one of the 16 control codes against a behavioural model, so each defined and undefined code is covered completely. The sweep includes every overflow boundary: -8, +7, the 0111+0001 wrap and the 1001+1111 carry without overflow. Directed tasks also pin those named corners separately.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_SUM  = 2'b10,
        OP_SUMX = 2'b11
    } op_sel_e;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    inv_a,
    input  logic    neg_b,
    input  logic    carry_in,
    input  op_sel_e sel,
    output logic    res_bit,
    output logic    carry_out
);

    logic a_eff;
    logic b_eff;
    logic sum_bit;

    always_comb begin
        a_eff     = a_bit ^ inv_a;
        b_eff     = b_bit ^ neg_b;
        sum_bit   = a_eff ^ b_eff ^ carry_in;
        carry_out = (a_eff & b_eff) | (carry_in & (a_eff ^ b_eff));
    end

    always_comb begin
        unique case (sel)
            OP_AND:  res_bit = a_eff & b_eff;
            OP_OR:   res_bit = a_eff | b_eff;
            OP_SUM:  res_bit = sum_bit;
            OP_SUMX: res_bit = sum_bit;
            default: res_bit = sum_bit;
        endcase
    end

    // R1: with both inputs 1 after inversion, the AND path cannot give 0
    always_comb begin
        if (!$isunknown({a_bit, b_bit, inv_a, neg_b, sel}) && sel == OP_AND
            && a_eff && b_eff)
            a_r1_and_ones: assert (res_bit);
    end

endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] result,
    input  logic             carry_into_msb,
    input  logic             carry_out_msb,
    input  logic             arith,
    output logic             flag_sign,
    output logic             flag_zero,
    output logic             flag_ovf,
    output logic             flag_carry
);

    localparam int MSB = WIDTH - 1;

    always_comb begin
        flag_sign  = result[MSB];
        flag_zero  = ~|result;
        flag_ovf   = arith & (carry_into_msb ^ carry_out_msb);
        flag_carry = arith & carry_out_msb;
    end

    // R8: a zero result can never be negative
    always_comb begin
        if (!$isunknown(result))
            a_r8_zero_not_neg: assert (!(flag_zero && flag_sign));
    end

endmodule

// File: rtl/alu_sliced_core.sv
module alu_sliced_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             inv_a,
    input  logic             neg_b,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             flag_sign,
    output logic             flag_zero,
    output logic             flag_ovf,
    output logic             flag_carry
);

    localparam int MSB = WIDTH - 1;

    op_sel_e          sel;
    logic [WIDTH:0]   carry;
    logic             arith;

    assign sel      = op_sel_e'(op_sel);
    assign arith    = op_sel[1];
    assign carry[0] = neg_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_bit     (opnd_a[i]),
            .b_bit     (opnd_b[i]),
            .inv_a     (inv_a),
            .neg_b     (neg_b),
            .carry_in  (carry[i]),
            .sel       (sel),
            .res_bit   (result[i]),
            .carry_out (carry[i+1])
        );
    end

    alu_status_flags #(.WIDTH(WIDTH)) u_flags (
        .result         (result),
        .carry_into_msb (carry[MSB]),
        .carry_out_msb  (carry[WIDTH]),
        .arith          (arith),
        .flag_sign      (flag_sign),
        .flag_zero      (flag_zero),
        .flag_ovf       (flag_ovf),
        .flag_carry     (flag_carry)
    );

    logic a_top_eff;
    logic b_top_eff;
    logic ctl_known;

    always_comb begin
        a_top_eff = opnd_a[MSB] ^ inv_a;
        b_top_eff = opnd_b[MSB] ^ neg_b;
        ctl_known = !$isunknown({opnd_a, opnd_b, inv_a, neg_b, op_sel});
        if (ctl_known) begin
            // R9: logical paths report no overflow and no carry
            if (!op_sel[1])
                a_r9_logic_no_flags: assert (!flag_ovf && !flag_carry);
            // R6: inputs of opposite sign cannot overflow
            if (op_sel[1] && (a_top_eff != b_top_eff))
                a_r6_mixed_no_ovf: assert (!flag_ovf);
            // R4: subtracting equal operands gives zero with carry set
            if (!inv_a && neg_b && op_sel == 2'b10 && opnd_a == opnd_b)
                a_r4_sub_self: assert (flag_zero && flag_carry && !flag_ovf);
        end
    end

endmodule

// File: tb/test_alu_sliced_core.sv
module test_alu_sliced_core;

    localparam int W = 4;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic [W-1:0] opnd_a, opnd_b, result;
    logic         inv_a, neg_b;
    logic [1:0]   op_sel;
    logic         flag_sign, flag_zero, flag_ovf, flag_carry;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    alu_sliced_core #(.WIDTH(W)) i_alu_sliced_core (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .inv_a(inv_a), .neg_b(neg_b),
        .op_sel(op_sel), .result(result), .flag_sign(flag_sign),
        .flag_zero(flag_zero), .flag_ovf(flag_ovf), .flag_carry(flag_carry)
    );

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ia, input logic nb, input logic [1:0] op);
        @(negedge clk);
        opnd_a = a; opnd_b = b; inv_a = ia; neg_b = nb; op_sel = op;
        #2;
    endtask

    task automatic check(input string req, input logic [W+3:0] act,
                         input logic [W+3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h ia=%b nb=%b op=%b actual=%h expected=%h",
                     req, opnd_a, opnd_b, inv_a, neg_b, op_sel, act, exp);
        end
    endtask

    // behavioural model: {result, sign, zero, ovf, carry}
    function automatic logic [W+3:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic ia, input logic nb, input logic [1:0] op);
        logic [W-1:0] ae, be, r;
        logic [W:0]   s;
        logic         ov, cy;
        ae = ia ? ~a : a;
        be = nb ? ~b : b;
        s  = {1'b0, ae} + {1'b0, be} + {{W{1'b0}}, nb};
        ov = 1'b0; cy = 1'b0;
        case (op)
            2'b00: r = ae & be;
            2'b01: r = ae | be;
            default: begin
                r  = s[W-1:0];
                cy = s[W];
                ov = (ae[W-1] == be[W-1]) && (r[W-1] != ae[W-1]);
            end
        endcase
        return {r, r[W-1], (r == '0), ov, cy};
    endfunction

    function automatic logic [W+3:0] observed();
        return {result, flag_sign, flag_zero, flag_ovf, flag_carry};
    endfunction

    task automatic t_idle_state();
        apply('0, '0, 1'b0, 1'b0, 2'b00);
        check("R8 idle zero", observed(), {{W{1'b0}}, 1'b0, 1'b1, 1'b0, 1'b0});
    endtask

    task automatic t_named_codes();
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                apply(W'(a), W'(b), 1'b0, 1'b0, 2'b00);
                check("R1 and", {28'd0, result}, {28'd0, W'(a) & W'(b)});
                apply(W'(a), W'(b), 1'b0, 1'b0, 2'b01);
                check("R2 or", {28'd0, result}, {28'd0, W'(a) | W'(b)});
                apply(W'(a), W'(b), 1'b0, 1'b0, 2'b10);
                check("R3 add", {27'd0, flag_carry, result}, {27'd0, 5'(a + b)});
                apply(W'(a), W'(b), 1'b0, 1'b1, 2'b10);
                check("R4 sub", {27'd0, flag_carry, result},
                      {27'd0, (a >= b), W'(a - b)});
                apply(W'(a), W'(b), 1'b1, 1'b1, 2'b00);
                check("R5 nor", {28'd0, result}, {28'd0, ~(W'(a) | W'(b))});
            end
        end
    endtask

    task automatic t_overflow_corners();
        apply(4'b0111, 4'b0001, 1'b0, 1'b0, 2'b10);
        check("R6 pos wrap", observed(), {4'b1000, 1'b1, 1'b0, 1'b1, 1'b0});
        apply(4'b1001, 4'b1111, 1'b0, 1'b0, 2'b10);
        check("R7 carry no ovf", observed(), {4'b1000, 1'b1, 1'b0, 1'b0, 1'b1});
        apply(4'b1000, 4'b1000, 1'b0, 1'b0, 2'b10);
        check("R6 neg wrap", observed(), {4'b0000, 1'b0, 1'b1, 1'b1, 1'b1});
        apply(4'b0111, 4'b1000, 1'b0, 1'b0, 2'b10);
        check("R6 mixed sign", observed(), {4'b1111, 1'b1, 1'b0, 1'b0, 1'b0});
        apply(4'b1000, 4'b0001, 1'b0, 1'b1, 2'b10);
        check("R6 sub ovf", observed(), {4'b0111, 1'b0, 1'b0, 1'b1, 1'b1});
    endtask

    // R8 R9 R10: every control code against the model
    task automatic t_all_codes();
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < N; a++) begin
                for (int b = 0; b < N; b++) begin
                    apply(W'(a), W'(b), c[3], c[2], c[1:0]);
                    check("R10 R9 R8 sweep", observed(),
                          model(W'(a), W'(b), c[3], c[2], c[1:0]));
                end
            end
        end
    endtask

    initial begin
        opnd_a = '0; opnd_b = '0; inv_a = 1'b0; neg_b = 1'b0; op_sel = 2'b00;
        t_idle_state();
        t_named_codes();
        t_overflow_corners();
        t_all_codes();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule